// File: doc/BRIEF.md
# Interlocked Handshake Burst Read Link

This block holds both ends of a read channel whose two parties never share a timing assumption. Every step waits for the other side to acknowledge the previous one. A requester engine takes a one-cycle start command carrying a word address and a burst flag. A memory-side engine answers it over a shared 4-word-wide data bus. Five handshake lines carry the conversation: read request, burst request, a memory acknowledge, data ready, and a requester acknowledge. Each engine passes the lines it receives from the other through a two-flop synchronizer before it acts on them.

A transaction opens with a single address handshake. The requester raises its read request, drives the address on the bus, and raises the burst request if it wants more than one group. The memory latches the address, acknowledges, and starts its first access at once, so the access overlaps the rest of the handshake. For each 4-word group, the memory drives the group and raises data ready. The requester captures the group and acknowledges. Both sides then return their lines low. In burst mode this data loop repeats for a configured number of groups, and the burst request falls together with the final acknowledge. Without the burst request, exactly one group is sent.

The memory engine reads its storage through a simple port: a word address out and a 4-word read value in, taken after a configurable number of cycles.

Top module: `hsk_burst_link`

## Requirements
- R1: After reset, every handshake line (readReqOut, burstReqOut, memAckOut, dataRdyOut, devAckOut) is low and busyOut and doneOut are low.
- R2: A start with startBurst=0 delivers exactly one group. grpValid pulses once, with grpIdx=0 and grpData holding memory words A, A+1, A+2, A+3, where word A+k sits in bits [32k+31:32k]. doneOut then pulses once.
- R3: A start with startBurst=1 delivers GRPS groups (4 by default) with grpIdx counting 0 upward. Group i holds the words at A+4i through A+4i+3 in the R2 layout, and word addresses wrap modulo 2^ADDR_W.
- R4: While readReqOut is high, the bus carries the start address zero-extended in its low ADDR_W bits. readReqOut stays high until memAckOut has been raised.
- R5: The bus is never driven by both sides in the same cycle; it reads zero when neither drives.
- R6: dataRdyOut rises only while memAckOut and devAckOut are both low.
- R7: devAckOut rises only while dataRdyOut is high.
- R8: burstReqOut rises only together with readReqOut, and falls only together with the final devAckOut fall of a burst. During a burst it holds its level throughout.
- R9: startIn is ignored while busyOut is high. A start pulse mid-burst changes neither the address nor the group count of the transfer in progress, and no new transfer follows it.
- R10: doneOut pulses for one cycle in the cycle busyOut falls, after the last group's acknowledge has been released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | One-cycle start command, honoured only when idle |
| startBurst | input | 1 | 1 = burst of GRPS groups, 0 = single group |
| startAddr | input | ADDR_W | First word address |
| busyOut | output | 1 | Requester is inside a transaction |
| doneOut | output | 1 | One-cycle end-of-transaction pulse |
| grpValid | output | 1 | One-cycle pulse: grpData/grpIdx carry a new group |
| grpIdx | output | CNT_W | Index of the captured group |
| grpData | output | 4*WORD_W | Captured 4-word group |
| memRdAddr | output | ADDR_W | Word address of the group the memory engine is reading |
| memRdData | input | 4*WORD_W | Four words at memRdAddr, taken after ACC_CYC cycles |
| readReqOut | output | 1 | Read request line |
| burstReqOut | output | 1 | Burst request line |
| memAckOut | output | 1 | Memory address acknowledge line |
| dataRdyOut | output | 1 | Data ready line |
| devAckOut | output | 1 | Requester data acknowledge line |
| busData | output | 4*WORD_W | Shared bus value |

## Verification
The assertions take for granted that rstN is held low for at least one edge at start-up. They also assume memRdData is a pure function of memRdAddr that stays stable for as long as that address does. The bench meets both: it holds reset for several cycles and derives memRdData combinationally from memRdAddr through a hashing function. The bench also pulses startIn mid-burst on purpose, because the design is required to ignore such a pulse. It drives every other start only after doneOut, which leaves the memory engine time to reach idle through the synchronizers.

// File: rtl/hskLinkPkg.sv
package hskLinkPkg;
  typedef struct packed {
    logic loadAddr;
    logic driveAddr;
    logic capture;
  } reqStrobe_t;

  typedef struct packed {
    logic latchAddr;
    logic loadData;
    logic driveData;
  } memStrobe_t;
endpackage

// File: rtl/syncBits.sv
module syncBits #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  for (genvar b = 0; b < W; b++) begin : gBit
    logic meta;
    logic stable;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        meta   <= 1'b0;
        stable <= 1'b0;
      end else begin
        meta   <= asyncIn[b];
        stable <= meta;
      end
    end
    assign syncOut[b] = stable;
  end
endmodule

// File: rtl/reqCtrl.sv
module reqCtrl
  import hskLinkPkg::*;
#(
  parameter int GRPS  = 4,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic             startBurst,
  input  logic             memAckS,
  input  logic             dataRdyS,
  output logic             readReq,
  output logic             burstReq,
  output logic             devAck,
  output logic             busyOut,
  output logic             doneOut,
  output logic             grpValid,
  output logic [CNT_W-1:0] grpIdx,
  output reqStrobe_t       stb
);
  typedef enum logic [1:0] {R_IDLE, R_ADDR, R_WAIT, R_ACK} rState_t;
  localparam logic [CNT_W-1:0] LAST_GRP = CNT_W'(GRPS - 1);

  rState_t          state;
  logic             burstMode;
  logic [CNT_W-1:0] cnt;
  logic             lastGrp;

  assign lastGrp = !burstMode || (cnt == LAST_GRP);

  always_comb begin
    stb.loadAddr  = (state == R_IDLE) && startIn;
    stb.driveAddr = (state == R_ADDR);
    stb.capture   = (state == R_WAIT) && dataRdyS;
  end

  assign busyOut = (state != R_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= R_IDLE;
      readReq   <= 1'b0;
      burstReq  <= 1'b0;
      devAck    <= 1'b0;
      doneOut   <= 1'b0;
      grpValid  <= 1'b0;
      grpIdx    <= '0;
      burstMode <= 1'b0;
      cnt       <= '0;
    end else begin
      doneOut  <= 1'b0;
      grpValid <= 1'b0;
      case (state)
        R_IDLE: if (startIn) begin
          readReq   <= 1'b1;
          burstReq  <= startBurst;
          burstMode <= startBurst;
          cnt       <= '0;
          state     <= R_ADDR;
        end
        R_ADDR: if (memAckS) begin
          readReq <= 1'b0;
          state   <= R_WAIT;
        end
        R_WAIT: if (dataRdyS) begin
          devAck   <= 1'b1;
          grpValid <= 1'b1;
          grpIdx   <= cnt;
          state    <= R_ACK;
        end
        R_ACK: if (!dataRdyS) begin
          devAck <= 1'b0;
          if (lastGrp) begin
            burstReq <= 1'b0;
            doneOut  <= 1'b1;
            state    <= R_IDLE;
          end else begin
            cnt   <= cnt + 1'b1;
            state <= R_WAIT;
          end
        end
        default: state <= R_IDLE;
      endcase
    end
  end

  // a new command is never taken mid-transaction
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    busyOut && startIn |=> $stable(burstMode) || !busyOut); // R9
endmodule

// File: rtl/memCtrl.sv
module memCtrl
  import hskLinkPkg::*;
#(
  parameter int GRPS    = 4,
  parameter int CNT_W   = 2,
  parameter int ACC_CYC = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             readReqS,
  input  logic             burstReqS,
  input  logic             devAckS,
  output logic             memAck,
  output logic             dataRdy,
  output logic [CNT_W-1:0] grp,
  output memStrobe_t       stb
);
  typedef enum logic [2:0] {M_IDLE, M_ACKH, M_ACC, M_DR, M_DL, M_FIN} mState_t;
  localparam int LAT_W = $clog2(ACC_CYC + 1);
  localparam logic [CNT_W-1:0] LAST_GRP = CNT_W'(GRPS - 1);
  localparam logic [LAT_W-1:0] LAT_LOAD = LAT_W'(ACC_CYC);

  mState_t          state;
  logic             burstMode;
  logic             lastSent;
  logic [LAT_W-1:0] accCnt;
  logic             accDone;

  assign accDone = (accCnt == '0);

  always_comb begin
    stb.latchAddr = (state == M_IDLE) && readReqS;
    stb.loadData  = (state == M_ACC) && accDone && !devAckS;
    stb.driveData = (state == M_DR);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= M_IDLE;
      memAck    <= 1'b0;
      dataRdy   <= 1'b0;
      grp       <= '0;
      burstMode <= 1'b0;
      lastSent  <= 1'b0;
      accCnt    <= '0;
    end else begin
      if (!accDone) accCnt <= accCnt - 1'b1;
      case (state)
        M_IDLE: if (readReqS) begin
          memAck    <= 1'b1;
          burstMode <= burstReqS;
          grp       <= '0;
          lastSent  <= 1'b0;
          accCnt    <= LAT_LOAD;
          state     <= M_ACKH;
        end
        M_ACKH: if (!readReqS) begin
          memAck <= 1'b0;
          state  <= M_ACC;
        end
        M_ACC: if (accDone && !devAckS) begin
          dataRdy <= 1'b1;
          state   <= M_DR;
        end
        M_DR: if (devAckS) begin
          dataRdy <= 1'b0;
          state   <= M_DL;
          if (burstMode && (grp != LAST_GRP)) begin
            grp    <= grp + 1'b1;
            accCnt <= LAT_LOAD;
          end else begin
            lastSent <= 1'b1;
          end
        end
        M_DL: if (!devAckS) begin
          if (lastSent || !burstReqS) state <= M_FIN;
          else                        state <= M_ACC;
        end
        M_FIN: if (!burstReqS) state <= M_IDLE;
        default: state <= M_IDLE;
      endcase
    end
  end

  // single-send transactions never advance past group 0
  AST_SINGLE_ONE_GROUP: assert property (@(posedge clk) disable iff (!rstN)
    dataRdy && !burstMode |-> grp == '0); // R2
endmodule

// File: rtl/linkDatapath.sv
module linkDatapath
  import hskLinkPkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  reqStrobe_t          reqStb,
  input  memStrobe_t          memStb,
  input  logic [ADDR_W-1:0]   startAddr,
  input  logic [CNT_W-1:0]    memGrp,
  input  logic [4*WORD_W-1:0] memRdData,
  output logic [4*WORD_W-1:0] busData,
  output logic [ADDR_W-1:0]   memRdAddr,
  output logic [4*WORD_W-1:0] grpData
);
  localparam int BUS_W = 4 * WORD_W;

  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] memBase;
  logic [BUS_W-1:0]  dataReg;

  always_comb begin
    if (reqStb.driveAddr)      busData = BUS_W'(addrReg);
    else if (memStb.driveData) busData = dataReg;
    else                       busData = '0;
  end

  assign memRdAddr = memBase + ADDR_W'({memGrp, 2'b00});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      memBase <= '0;
      dataReg <= '0;
      grpData <= '0;
    end else begin
      if (reqStb.loadAddr)  addrReg <= startAddr;
      if (memStb.latchAddr) memBase <= busData[ADDR_W-1:0];
      if (memStb.loadData)  dataReg <= memRdData;
      if (reqStb.capture)   grpData <= busData;
    end
  end

  AST_BUS_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({reqStb.driveAddr, memStb.driveData})); // R5
  AST_ADDR_LATCH_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    memStb.latchAddr |-> reqStb.driveAddr); // R4
endmodule

// File: rtl/hsk_burst_link.sv
module hsk_burst_link
  import hskLinkPkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int ADDR_W  = 16,
  parameter int GRPS    = 4,
  parameter int ACC_CYC = 6,
  localparam int CNT_W  = (GRPS > 1) ? $clog2(GRPS) : 1,
  localparam int BUS_W  = 4 * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic              startBurst,
  input  logic [ADDR_W-1:0] startAddr,
  output logic              busyOut,
  output logic              doneOut,
  output logic              grpValid,
  output logic [CNT_W-1:0]  grpIdx,
  output logic [BUS_W-1:0]  grpData,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [BUS_W-1:0]  memRdData,
  output logic              readReqOut,
  output logic              burstReqOut,
  output logic              memAckOut,
  output logic              dataRdyOut,
  output logic              devAckOut,
  output logic [BUS_W-1:0]  busData
);
  reqStrobe_t       reqStb;
  memStrobe_t       memStb;
  logic [1:0]       reqSeen;
  logic [2:0]       memSeen;
  logic [CNT_W-1:0] memGrp;

  syncBits #(.W(2)) uReqSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({memAckOut, dataRdyOut}), .syncOut(reqSeen)
  );

  syncBits #(.W(3)) uMemSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({readReqOut, burstReqOut, devAckOut}), .syncOut(memSeen)
  );

  reqCtrl #(.GRPS(GRPS), .CNT_W(CNT_W)) uReq (
    .clk(clk), .rstN(rstN),
    .startIn(startIn), .startBurst(startBurst),
    .memAckS(reqSeen[1]), .dataRdyS(reqSeen[0]),
    .readReq(readReqOut), .burstReq(burstReqOut), .devAck(devAckOut),
    .busyOut(busyOut), .doneOut(doneOut),
    .grpValid(grpValid), .grpIdx(grpIdx), .stb(reqStb)
  );

  memCtrl #(.GRPS(GRPS), .CNT_W(CNT_W), .ACC_CYC(ACC_CYC)) uMem (
    .clk(clk), .rstN(rstN),
    .readReqS(memSeen[2]), .burstReqS(memSeen[1]), .devAckS(memSeen[0]),
    .memAck(memAckOut), .dataRdy(dataRdyOut), .grp(memGrp), .stb(memStb)
  );

  linkDatapath #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN),
    .reqStb(reqStb), .memStb(memStb),
    .startAddr(startAddr), .memGrp(memGrp), .memRdData(memRdData),
    .busData(busData), .memRdAddr(memRdAddr), .grpData(grpData)
  );

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    readReqOut && !memAckOut |=> readReqOut); // R4
  AST_RDY_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataRdyOut) |-> !memAckOut && !devAckOut); // R6
  AST_ACK_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(devAckOut) |-> dataRdyOut); // R7
  AST_BURST_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(burstReqOut) |-> $rose(readReqOut)); // R8
  AST_BURST_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(burstReqOut) |-> $fell(devAckOut) && doneOut); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> $past(busyOut) && !$past(devAckOut, 1) == 1'b0); // R10
endmodule

// File: tb/sim_hsk_burst_link.sv
module sim_hsk_burst_link;
  localparam int CLK_NS = 10;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 16;
  localparam int GRPS   = 4;
  localparam int CNT_W  = 2;
  localparam int BUS_W  = 4 * WORD_W;
  localparam int NVEC   = 6;

  // {burst, expected group count, start address}
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b0, 3'd1, 16'h0010},
    {1'b1, 3'd4, 16'h0100},
    {1'b0, 3'd1, 16'h7FFF},
    {1'b1, 3'd4, 16'hFFF8},
    {1'b1, 3'd4, 16'h0003},
    {1'b0, 3'd1, 16'hFFFE}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startIn = 1'b0;
  logic              startBurst = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic              busyOut, doneOut, grpValid;
  logic [CNT_W-1:0]  grpIdx;
  logic [BUS_W-1:0]  grpData, busData, memRdData;
  logic [ADDR_W-1:0] memRdAddr;
  logic              readReqOut, burstReqOut, memAckOut, dataRdyOut, devAckOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_NS / 2) clk = ~clk;

  function automatic logic [WORD_W-1:0] memWord(logic [ADDR_W-1:0] a);
    return (WORD_W'(a) * 32'h0000_9E37) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [BUS_W-1:0] memGroup(logic [ADDR_W-1:0] a);
    logic [BUS_W-1:0] g;
    for (int k = 0; k < 4; k++) g[k*WORD_W +: WORD_W] = memWord(a + ADDR_W'(k));
    return g;
  endfunction

  assign memRdData = memGroup(memRdAddr);

  hsk_burst_link #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .GRPS(GRPS), .ACC_CYC(6)) u0 (
    .clk(clk), .rstN(rstN), .startIn(startIn), .startBurst(startBurst),
    .startAddr(startAddr), .busyOut(busyOut), .doneOut(doneOut),
    .grpValid(grpValid), .grpIdx(grpIdx), .grpData(grpData),
    .memRdAddr(memRdAddr), .memRdData(memRdData),
    .readReqOut(readReqOut), .burstReqOut(burstReqOut), .memAckOut(memAckOut),
    .dataRdyOut(dataRdyOut), .devAckOut(devAckOut), .busData(busData)
  );

  task automatic check(bit ok, string req, logic [BUS_W-1:0] act, logic [BUS_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runTxn(logic [ADDR_W-1:0] addr, bit burst, int expN, bit interfere);
    int got = 0;
    int cyc = 0;
    bit addrSeen = 0;
    bit sawDone = 0;
    @(negedge clk);
    startIn = 1'b1; startBurst = burst; startAddr = addr;
    @(negedge clk);
    startIn = 1'b0; startAddr = ~addr;
    while (!sawDone && cyc < 3000) begin
      if (startIn) startIn = 1'b0;
      if (readReqOut && !addrSeen) begin
        addrSeen = 1;
        check(busData[ADDR_W-1:0] == addr, "R4 address on bus", BUS_W'(busData[ADDR_W-1:0]), BUS_W'(addr));
        check(burstReqOut == burst, "R8 burst level with request", BUS_W'(burstReqOut), BUS_W'(burst));
      end
      if (busyOut && !doneOut && got > 0 && got < expN && burst)
        if (!burstReqOut) check(0, "R8 burst held", 0, 1);
      if (grpValid) begin
        check(grpIdx == CNT_W'(got), burst ? "R3 group index" : "R2 group index", BUS_W'(grpIdx), BUS_W'(got));
        check(grpData == memGroup(addr + ADDR_W'(4 * got)), burst ? "R3 group data" : "R2 group data",
              grpData, memGroup(addr + ADDR_W'(4 * got)));
        got++;
        if (interfere && got == 2) begin
          startIn = 1'b1; startBurst = 1'b0; startAddr = 16'h5555;  // R9 stray start
        end
      end
      if (doneOut) begin
        sawDone = 1;
        check(!busyOut, "R10 busy low with done", BUS_W'(busyOut), 0);
        check(!devAckOut && !dataRdyOut, "R10 lines released", BUS_W'({devAckOut, dataRdyOut}), 0);
      end
      @(negedge clk);
      cyc++;
    end
    startIn = 1'b0;
    check(sawDone, "R10 done pulse seen", BUS_W'(sawDone), 1);
    check(got == expN, burst ? "R3 group count" : "R2 group count", BUS_W'(got), BUS_W'(expN));
    check(!doneOut, "R10 done lasts one cycle", BUS_W'(doneOut), 0);
    repeat (20) @(negedge clk);
    if (interfere) begin
      check(!busyOut && !readReqOut, "R9 no transfer from stray start",
            BUS_W'({busyOut, readReqOut}), 0);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check({readReqOut, burstReqOut, memAckOut, dataRdyOut, devAckOut} == 5'b0,
          "R1 lines low in reset", BUS_W'({readReqOut, burstReqOut, memAckOut, dataRdyOut, devAckOut}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busyOut && !doneOut, "R1 idle after reset", BUS_W'({busyOut, doneOut}), 0);
    check(busData == '0, "R5 idle bus reads zero", busData, 0);

    for (int v = 0; v < NVEC; v++)
      runTxn(VEC[v][15:0], VEC[v][19], int'(VEC[v][18:16]), 1'b0);

    // R9: a start pulse in the middle of a burst
    runTxn(16'h0440, 1'b1, GRPS, 1'b1);
    // back-to-back single after the ignored start still works
    runTxn(16'h0040, 1'b0, 1, 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule